// File: doc/BRIEF.md
# Shared Multiply and Barrel-Shift Execution Unit

This integer execution unit runs all of its operations through one signed 33x33 multiplier. A 32-bit multiply takes either the low half or the high half of the product. A shift multiplies the operand by a power of two. A left shift by n uses 2^n and keeps the low word. A right shift by n uses 2^(32-n) and keeps the high word. The operand is zero-extended for a logical right shift and sign-extended for an arithmetic right shift, so the same multiplier serves both kinds. Every result is a single 32-bit word meant for the general register file. No product is kept in side registers.

The unit is not pipelined. It takes one operation at a time through a start/busy/done handshake. A parameter sets the latency to 2 or 3 cycles. The 3-cycle setting adds a second register after the multiplier, which trades one cycle of latency for a shorter logic path. The shift amount comes from a 5-bit immediate input or from the low 5 bits of the second operand.

Top module: `shmul_unit`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are 0 and result is 0.
- R2: Start is accepted when busy is low. Busy is high from the cycle after the accepted start. After LATENCY cycles (2 or 3), done is high for exactly one cycle and busy falls in that same cycle.
- R3: A start raised while busy is high is ignored: the running operation keeps its timing and its result.
- R4: op code 0 (left shift) returns opa shifted left by the amount, with zeros filled in.
- R5: op code 1 (logical right shift) returns opa shifted right by the amount, with zeros filled in.
- R6: op code 2 (arithmetic right shift) returns opa shifted right by the amount, with copies of opa bit 31 filled in.
- R7: A shift by an amount of zero returns opa unchanged, for all three shift codes.
- R8: When amt_from_imm is 1 the amount is imm_amt. When it is 0 the amount is opb bits 4:0, and opb bits 31:5 and imm_amt have no effect.
- R9: op code 3 returns bits 31:0 of opa*opb. Codes 6 and 7 behave like code 3.
- R10: op code 4 returns bits 63:32 of the unsigned product of opa and opb.
- R11: op code 5 returns bits 63:32 of the signed product of opa and opb.
- R12: result changes only in the cycle where done is high, and it holds its value until the next operation completes, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code (see R4 to R11) |
| amt_from_imm | input | 1 | 1 selects imm_amt as the shift amount, 0 selects opb[4:0] |
| imm_amt | input | 5 | Immediate shift amount |
| opa | input | 32 | First operand, the value that is shifted |
| opb | input | 32 | Second operand or register shift amount |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 32 | Result of the last completed operation |

## Verification
A wrong multiplicand, such as a power of two off by one position or the wrong extension of the operand, shows up as a wrong result word in the done cycle of that same operation. The bench therefore runs every shift amount with operands whose top bit is set and with operands whose top bit is clear. A control counter that is off by one moves the done pulse by a cycle or stretches busy, and that is visible on the first operation after reset. A stray start that is accepted while the unit is busy corrupts the result or the done timing within the same operation window. Running two instances side by side, one with each latency setting, shows which latency path holds a fault.

// File: rtl/shmul_pkg.sv
package shmul_pkg;
   typedef enum logic [2:0] {
      OP_SLL   = 3'd0,
      OP_SRL   = 3'd1,
      OP_SRA   = 3'd2,
      OP_MULLO = 3'd3,
      OP_MULHU = 3'd4,
      OP_MULHS = 3'd5
   } shmul_op_e;
endpackage

// File: rtl/shmul_decode.sv
// Turns an operation into two extended multiplicands and a half-select.
module shmul_decode #(
   parameter int DATA_W = 32,
   localparam int SH_W = $clog2(DATA_W)
) (
   input  logic [2:0]        op,
   input  logic              amt_from_imm,
   input  logic [SH_W-1:0]   imm_amt,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W:0]   mul_a,
   output logic [DATA_W:0]   mul_b,
   output logic              take_hi
);
   import shmul_pkg::*;

   logic [SH_W-1:0] shamt;
   logic [DATA_W:0] pow_left, pow_right, a_zx, a_sx, b_zx, b_sx;
   logic            zero_amt;

   always_comb begin
      shamt     = amt_from_imm ? imm_amt : opb[SH_W-1:0];
      zero_amt  = (shamt == '0);
      pow_left  = {{DATA_W{1'b0}}, 1'b1} << shamt;
      pow_right = {1'b1, {DATA_W{1'b0}}} >> shamt;
      a_zx      = {1'b0, opa};
      a_sx      = {opa[DATA_W-1], opa};
      b_zx      = {1'b0, opb};
      b_sx      = {opb[DATA_W-1], opb};
   end

   always_comb begin
      mul_a   = a_zx;
      mul_b   = b_zx;
      take_hi = 1'b0;
      case (op)
         OP_SLL: begin
            mul_b = pow_left;
         end
         OP_SRL: begin
            mul_b   = zero_amt ? {{DATA_W{1'b0}}, 1'b1} : pow_right;
            take_hi = !zero_amt;
         end
         OP_SRA: begin
            mul_a   = a_sx;
            mul_b   = zero_amt ? {{DATA_W{1'b0}}, 1'b1} : pow_right;
            take_hi = !zero_amt;
         end
         OP_MULHU: begin
            take_hi = 1'b1;
         end
         OP_MULHS: begin
            mul_a   = a_sx;
            mul_b   = b_sx;
            take_hi = 1'b1;
         end
         default: begin
            mul_a = a_zx;
         end
      endcase
   end
endmodule

// File: rtl/shmul_mult_core.sv
// Operand registers, one shared signed multiplier, 1 or 2 product stages.
module shmul_mult_core #(
   parameter int DATA_W  = 32,
   parameter int LATENCY = 2,
   localparam int OPND_W = DATA_W + 1,
   localparam int PROD_W = 2 * OPND_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W:0]   a_in,
   input  logic [DATA_W:0]   b_in,
   input  logic              take_hi_in,
   output logic [DATA_W-1:0] word
);
   logic signed [OPND_W-1:0] a_q, b_q;
   logic                     hi_q;
   logic signed [PROD_W-1:0] prod, prod_q, prod_fin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q  <= '0;
         b_q  <= '0;
         hi_q <= 1'b0;
      end else if (load) begin
         a_q  <= a_in;
         b_q  <= b_in;
         hi_q <= take_hi_in;
      end
   end

   assign prod = a_q * b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else        prod_q <= prod;
   end

   generate
      if (LATENCY == 3) begin : g_two_stage
         logic signed [PROD_W-1:0] prod_q2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_q2 <= '0;
            else        prod_q2 <= prod_q;
         end
         assign prod_fin = prod_q2;
      end else begin : g_one_stage
         assign prod_fin = prod_q;
      end
   endgenerate

   assign word = hi_q ? prod_fin[2*DATA_W-1:DATA_W] : prod_fin[DATA_W-1:0];
endmodule

// File: rtl/shmul_ctrl.sv
// Handshake sequencer: accepts one start, counts LATENCY cycles.
module shmul_ctrl #(
   parameter int LATENCY = 2,
   localparam int CNT_W = $clog2(LATENCY + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic capture,
   output logic busy,
   output logic done
);
   logic [CNT_W-1:0] cnt;

   assign accept  = start && !busy;
   assign capture = busy && (cnt == CNT_W'(LATENCY - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= capture;
         if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (capture) begin
            busy <= 1'b0;
         end else if (busy) begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/shmul_unit.sv
module shmul_unit #(
   parameter int DATA_W  = 32,
   parameter int LATENCY = 2,
   localparam int SH_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic              amt_from_imm,
   input  logic [SH_W-1:0]   imm_amt,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result
);
   generate
      if (LATENCY != 2 && LATENCY != 3) begin : g_bad_latency
         $error("shmul_unit: LATENCY must be 2 or 3");
      end
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("shmul_unit: DATA_W must be a power of two, at least 8");
      end
   endgenerate

   logic [DATA_W:0]   mul_a, mul_b;
   logic              take_hi, accept, capture;
   logic [DATA_W-1:0] word;

   shmul_decode #(.DATA_W(DATA_W)) u_decode (
      .op(op), .amt_from_imm(amt_from_imm), .imm_amt(imm_amt),
      .opa(opa), .opb(opb),
      .mul_a(mul_a), .mul_b(mul_b), .take_hi(take_hi)
   );

   shmul_mult_core #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_core (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .a_in(mul_a), .b_in(mul_b), .take_hi_in(take_hi),
      .word(word)
   );

   shmul_ctrl #(.LATENCY(LATENCY)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .accept(accept), .capture(capture), .busy(busy), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       result <= '0;
      else if (capture) result <= word;
   end
endmodule

// File: rtl/shmul_unit_chk.sv
module shmul_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int LATENCY = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] result
);
   int unsigned bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bcnt <= 0;
      else if (busy) bcnt <= bcnt + 1;
      else           bcnt <= 0;
   end

   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done && result == '0));

   a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r2_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bcnt == LATENCY));

   a_r3_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bcnt < LATENCY));

   a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
endmodule

bind shmul_unit shmul_unit_chk #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start),
   .busy(busy), .done(done), .result(result)
);

// File: tb/shmul_unit_tb.sv
module shmul_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 16;

   // {op, amt_from_imm, imm_amt, opa, opb}
   localparam logic [72:0] VEC [NVEC] = '{
      {3'd3, 1'b1, 5'd0,  32'h0000_0007, 32'h0000_0006},
      {3'd3, 1'b1, 5'd0,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {3'd4, 1'b1, 5'd0,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {3'd5, 1'b1, 5'd0,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {3'd5, 1'b1, 5'd0,  32'h8000_0000, 32'h8000_0000},
      {3'd4, 1'b1, 5'd0,  32'h8000_0000, 32'h0000_0002},
      {3'd5, 1'b1, 5'd0,  32'h8000_0000, 32'h7FFF_FFFF},
      {3'd0, 1'b1, 5'd4,  32'h0000_1234, 32'hDEAD_BEEF},
      {3'd1, 1'b1, 5'd31, 32'h8000_0000, 32'h0000_0000},
      {3'd2, 1'b1, 5'd31, 32'h8000_0000, 32'h0000_0000},
      {3'd2, 1'b1, 5'd1,  32'h7FFF_FFFE, 32'h0000_0000},
      {3'd0, 1'b0, 5'd17, 32'h0000_0001, 32'hFFFF_FFE3},
      {3'd1, 1'b0, 5'd9,  32'hCAFE_F00D, 32'h0000_0120},
      {3'd2, 1'b0, 5'd5,  32'hF000_0000, 32'h1234_5682},
      {3'd0, 1'b1, 5'd31, 32'h0000_0003, 32'h0000_0000},
      {3'd7, 1'b1, 5'd0,  32'h0001_0003, 32'h0002_0005}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = '0;
   logic        amt_from_imm = 1'b0;
   logic [4:0]  imm_amt = '0;
   logic [31:0] opa = '0, opb = '0;
   logic        busy2, done2, busy3, done3;
   logic [31:0] res2, res3;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] rng = 32'h1A2B_3C4D;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shmul_unit #(.DATA_W(32), .LATENCY(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .amt_from_imm(amt_from_imm), .imm_amt(imm_amt), .opa(opa), .opb(opb),
      .busy(busy2), .done(done2), .result(res2)
   );

   shmul_unit #(.DATA_W(32), .LATENCY(3)) u_dut_l3 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .amt_from_imm(amt_from_imm), .imm_amt(imm_amt), .opa(opa), .opb(opb),
      .busy(busy3), .done(done3), .result(res3)
   );

   function automatic logic [31:0] next_rand();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      return rng;
   endfunction

   function automatic logic [31:0] model(input logic [2:0] o, input logic ui,
                                         input logic [4:0] im, input logic [31:0] a,
                                         input logic [31:0] b);
      logic [4:0]         n;
      logic [63:0]        pu;
      logic signed [63:0] ps;
      n  = ui ? im : b[4:0];
      pu = {32'b0, a} * {32'b0, b};
      ps = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
      case (o)
         3'd0:    return a << n;
         3'd1:    return a >> n;
         3'd2:    return $unsigned($signed(a) >>> n);
         3'd4:    return pu[63:32];
         3'd5:    return ps[63:32];
         default: return pu[31:0];
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] o, input logic ui,
                                    input logic [4:0] im, input logic [31:0] b);
      logic [4:0] n;
      n = ui ? im : b[4:0];
      if (o <= 3'd2 && n == 0) return "R7";
      if (o <= 3'd2 && !ui)    return "R8";
      case (o)
         3'd0:    return "R4";
         3'd1:    return "R5";
         3'd2:    return "R6";
         3'd4:    return "R10";
         3'd5:    return "R11";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One operation on both instances. poke raises start again while busy (R3).
   task automatic run_op(input logic [2:0] o, input logic ui, input logic [4:0] im,
                         input logic [31:0] a, input logic [31:0] b,
                         input string tag, input bit poke);
      logic [31:0] exp, r2, r3;
      bit hs_ok;
      exp   = model(o, ui, im, a, b);
      hs_ok = 1'b1;
      r2    = '0;
      r3    = '0;
      @(negedge clk);
      op = o; amt_from_imm = ui; imm_amt = im; opa = a; opb = b; start = 1'b1;
      for (int c = 1; c <= 5; c++) begin
         @(negedge clk);
         if (busy2 !== (c < 3) || done2 !== (c == 3)) hs_ok = 1'b0;
         if (busy3 !== (c < 4) || done3 !== (c == 4)) hs_ok = 1'b0;
         if (c == 3) r2 = res2;
         if (c == 4) r3 = res3;
         start = (c == 1) && poke;
         op    = next_rand()[2:0];
         amt_from_imm = rng[8];
         imm_amt = rng[14:10];
         opa = next_rand();
         opb = next_rand();
      end
      check(hs_ok, "R2 handshake", {busy2, done2, busy3, done3}, 32'h0);
      check(r2 === exp, {tag, " lat2"}, r2, exp);
      check(r3 === exp, {tag, " lat3"}, r3, exp);
      check(res2 === exp && res3 === exp, "R12 hold", res2 ^ res3, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!busy2 && !done2 && res2 == 0 && !busy3 && !done3 && res3 == 0,
            "R1 in reset", res2 | res3, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy2 && !done2 && res2 == 0 && !busy3 && !done3 && res3 == 0,
            "R1 after reset", res2 | res3, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         run_op(VEC[i][72:70], VEC[i][69], VEC[i][68:64], VEC[i][63:32], VEC[i][31:0],
                tag_of(VEC[i][72:70], VEC[i][69], VEC[i][68:64], VEC[i][31:0]), 1'b0);
      end

      // R4 R5 R6 R7 R8: every shift amount, immediate and register, both sign patterns
      for (int s = 0; s < 32; s++) begin
         for (int o = 0; o < 3; o++) begin
            run_op(3'(o), 1'b1, 5'(s), 32'h8642_1357, 32'hFFFF_FFE0,
                   tag_of(3'(o), 1'b1, 5'(s), 0), 1'b0);
            run_op(3'(o), 1'b0, ~5'(s), 32'h7531_ECA9, {next_rand()[31:5], 5'(s)},
                   tag_of(3'(o), 1'b0, 0, 32'(s)), 1'b0);
         end
      end

      // R3: start raised while busy must not disturb the running operation
      run_op(3'd5, 1'b1, 5'd0, 32'h8000_0001, 32'h0000_0003, "R3", 1'b1);
      run_op(3'd2, 1'b1, 5'd7, 32'h9000_0000, 32'h0, "R3", 1'b1);

      // random operands across all codes
      for (int k = 0; k < 120; k++) begin
         logic [2:0]  ro;
         logic [31:0] ra, rb;
         ro = next_rand()[2:0];
         ra = next_rand();
         rb = next_rand();
         run_op(ro, rng[3], rng[9:5], ra, rb, tag_of(ro, rng[3], rng[9:5], rb), 1'b0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule